// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor and a slower word-wide backing memory. Each 32-bit byte address is cut into a byte-in-word field, a word-in-line field, a line index and a tag. A tag table keeps, for every line, the stored tag, a valid bit and a dirty bit. Reads that hit return the addressed word at once. Writes that hit merge one, two or four bytes into the stored word and mark the line dirty.

On a miss the controller stalls the processor. It copies a dirty victim line out to backing memory one word at a time and then loads the whole new line. After that it replays the held request as a hit. Line length and line count are parameters. The backing port carries one word per request/acknowledge handshake.

The processor holds its request, with address, size and data unchanged, until it sees ready. Only one access is in flight at a time.

Top module: `dcache_ctl`

## Requirements
- R1: The address fields are cut as follows. Bits 1:0 pick the byte. The next log2(BLK_WORDS) bits pick the word in the line. The next log2(NUM_BLK) bits pick the line. The remaining upper bits are the tag. Every backing-memory address is word aligned (bits 1:0 zero) and is built as {tag, index, word counter, 2'b00}.
- R2: Reset marks every line invalid and clean. While in reset, cpu_ready and mem_req are low. A dirty line present before reset is not written back afterwards.
- R3: A read whose line is valid and whose stored tag matches returns the whole stored word on cpu_rdata. This happens in the same cycle that cpu_ready is high, without any backing-memory traffic.
- R4: A write hit updates bytes according to cpu_size. Code 2'b00 writes cpu_wdata[7:0] into byte addr[1:0]. Code 2'b01 writes cpu_wdata[15:0] into the half picked by addr[1] (addr[0] is ignored). Codes 2'b10 and 2'b11 write the full word. All other bytes keep their value, and the line becomes dirty.
- R5: A miss on an empty or clean line does no write-back. It reads BLK_WORDS words with the new tag, in ascending word order starting at word 0.
- R6: A miss on a dirty line first writes all BLK_WORDS words of the resident line, in ascending order, to addresses built from the stored tag. The data written is the line's current content. Only then does any fill read start.
- R7: After a fill the line is valid and clean. The held request then completes as a hit, so a later eviction of a line that was only read does no write-back.
- R8: A write miss completes with its write applied after the fill, so the line ends dirty and its next eviction writes it back.
- R9: cpu_ready is high only while cpu_req is high, and never while a backing-memory request is open. It stays low from the first cycle of miss handling until the replayed access.
- R10: While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle.
- R11: With no processor request pending, the controller raises no backing-memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 byte, 01 half, 10/11 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, low-aligned for byte and half |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Addressed word, valid with cpu_ready on reads |
| mem_req | output | 1 | Backing-memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 32 | Word-aligned backing-memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Transfer of current word accepted |
| mem_rdata | input | 32 | Fill data, valid with mem_ack on reads |

## Verification
Two things land in the same clock edge on the last fill beat: the word from backing memory is written into the data array, and the tag table sets the tag and valid bit and clears the dirty bit. On the next cycle the replayed request looks up both. The write-miss vectors provoke this case, because their replay writes into a word of the line that was just filled. The result is judged by a later read of that word, and by the exact address and data of the write-back that eventually evicts the line. A second overlap covers the last write-back beat, where the word counter wraps and the fill begins. Ordering checks on every backing-memory beat confirm that no fill read comes before the final write-back word.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output logic             lk_valid,
    output logic             lk_dirty,
    input  logic             mark_dirty,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic             fill_done,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [TAG_W-1:0]   tag_mem [ENTRIES];
    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [ENTRIES-1:0] dirty_d, dirty_q;

    assign lk_tag   = tag_mem[lk_idx];
    assign lk_valid = valid_q[lk_idx];
    assign lk_dirty = dirty_q[lk_idx];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (fill_done) begin
            valid_d[fill_idx] = 1'b1;
            dirty_d[fill_idx] = 1'b0;
        end
        if (mark_dirty) begin
            dirty_d[mark_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_mem[fill_idx] <= fill_tag;
        end
    end

endmodule

// File: rtl/dcache_data_ram.sv
module dcache_data_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [3:0]    lane_we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < 4; l++) begin
                if (lane_we[l]) begin
                    mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dcache_ctl.sv
module dcache_ctl #(
    parameter int BLK_WORDS = 16,
    parameter int NUM_BLK   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    import dcache_pkg::*;

    localparam int OFF_W   = $clog2(BLK_WORDS);
    localparam int IDX_W   = $clog2(NUM_BLK);
    localparam int LINE_AW = IDX_W + OFF_W;
    localparam int TAG_W   = 30 - LINE_AW;
    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(BLK_WORDS - 1);

    typedef struct packed {
        ctl_state_e       st;
        logic [OFF_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] new_tag;
        logic [TAG_W-1:0] old_tag;
    } ctl_regs_t;

    ctl_regs_t d, q;

    logic [OFF_W-1:0] c_word;
    logic [IDX_W-1:0] c_idx;
    logic [TAG_W-1:0] c_tag;

    assign c_word = cpu_addr[OFF_W+1:2];
    assign c_idx  = cpu_addr[LINE_AW+1:OFF_W+2];
    assign c_tag  = cpu_addr[31:LINE_AW+2];

    // byte lane steering for partial writes
    logic [3:0]  lane_sel;
    logic [31:0] lane_data;

    for (genvar l = 0; l < 4; l++) begin : g_lane
        assign lane_sel[l] = (cpu_size == SZ_BYTE) ? (cpu_addr[1:0] == 2'(l)) :
                             (cpu_size == SZ_HALF) ? (cpu_addr[1] == 1'(l / 2)) :
                             1'b1;
        assign lane_data[8*l +: 8] = (cpu_size == SZ_BYTE) ? cpu_wdata[7:0] :
                                     (cpu_size == SZ_HALF) ? cpu_wdata[8*(l%2) +: 8] :
                                     cpu_wdata[8*l +: 8];
    end

    logic [IDX_W-1:0]   lk_idx;
    logic [TAG_W-1:0]   lk_tag;
    logic               lk_valid;
    logic               lk_dirty;
    logic               hit;
    logic               mark_dirty;
    logic               fill_done;
    logic               ram_we;
    logic [3:0]         ram_lanes;
    logic [LINE_AW-1:0] ram_waddr;
    logic [LINE_AW-1:0] ram_raddr;
    logic [31:0]        ram_wdata;
    logic [31:0]        ram_rdata;

    dcache_tag_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (lk_idx),
        .lk_tag     (lk_tag),
        .lk_valid   (lk_valid),
        .lk_dirty   (lk_dirty),
        .mark_dirty (mark_dirty),
        .mark_idx   (c_idx),
        .fill_done  (fill_done),
        .fill_idx   (q.idx),
        .fill_tag   (q.new_tag)
    );

    dcache_data_ram #(
        .AW (LINE_AW)
    ) u_data (
        .clk     (clk),
        .we      (ram_we),
        .lane_we (ram_lanes),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr   (ram_raddr),
        .rdata   (ram_rdata)
    );

    assign cpu_rdata = ram_rdata;
    assign mem_wdata = ram_rdata;

    always_comb begin
        d          = q;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        ram_we     = 1'b0;
        ram_lanes  = '0;
        ram_waddr  = {c_idx, c_word};
        ram_wdata  = lane_data;
        mark_dirty = 1'b0;
        fill_done  = 1'b0;
        lk_idx     = (q.st == ST_IDLE) ? c_idx : q.idx;
        ram_raddr  = (q.st == ST_IDLE) ? {c_idx, c_word} : {q.idx, q.cnt};
        hit        = lk_valid && (lk_tag == c_tag);

        case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            ram_we     = 1'b1;
                            ram_lanes  = lane_sel;
                            mark_dirty = 1'b1;
                        end
                    end else begin
                        d.idx     = c_idx;
                        d.new_tag = c_tag;
                        d.old_tag = lk_tag;
                        d.cnt     = '0;
                        d.st      = (lk_valid && lk_dirty) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {q.old_tag, q.idx, q.cnt, 2'b00};
                if (mem_ack) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_WORD) begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {q.new_tag, q.idx, q.cnt, 2'b00};
                if (mem_ack) begin
                    ram_we    = 1'b1;
                    ram_lanes = 4'hF;
                    ram_waddr = {q.idx, q.cnt};
                    ram_wdata = mem_rdata;
                    d.cnt     = q.cnt + 1'b1;
                    if (q.cnt == LAST_WORD) begin
                        fill_done = 1'b1;
                        d.st      = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dcache_ctl_chk.sv
module dcache_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata
);

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R9
    ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R1
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && !mem_req) |=> !mem_req);

endmodule

bind dcache_ctl dcache_ctl_chk u_ctl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/dcache_ctl_tb_top.sv
module dcache_ctl_tb_top;

    localparam int BW = 4;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req;
    logic        cpu_we;
    logic [1:0]  cpu_size;
    logic [31:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk;

    dcache_ctl #(.BLK_WORDS(BW), .NUM_BLK(NB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // backing store and processor-visible reference
    logic [31:0] bmem [logic [31:0]];
    logic [31:0] refm [logic [31:0]];

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h3C3C_0F0F;
    endfunction

    function automatic logic [31:0] bm_rd(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : init_val(a);
    endfunction

    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        return refm.exists(a) ? refm[a] : bm_rd(a);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [1:0] sz,
                                          input logic [31:0] a, input logic [31:0] wd);
        logic [31:0] r = old;
        case (sz)
            2'b00:   r[8*a[1:0] +: 8] = wd[7:0];
            2'b01:   r[16*a[1] +: 16] = wd[15:0];
            default: r = wd;
        endcase
        return r;
    endfunction

    // shadow tag table (fields: word 3:2, index 5:4, tag 31:6)
    logic [25:0] sh_tag [NB];
    bit          sh_v   [NB];
    bit          sh_d   [NB];

    // backing memory responder and per-beat monitor
    int          wb_n, fill_n, mem_seen, wait_cnt;
    logic [31:0] wb_base, fill_base, prev_addr;
    bit          prev_wait, prev_we;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack   = 1'b0;
            mem_rdata = '0;
            wait_cnt  = 0;
            prev_wait = 0;
        end else begin
            if (prev_wait) begin
                chk(mem_req && mem_addr == prev_addr && mem_we == prev_we,
                    "R10 held request", mem_addr, prev_addr);
            end
            if (mem_req) begin
                mem_seen++;
                chk(!cpu_ready, "R9 ready during memory traffic", 32'(cpu_ready), 32'd0);
            end
            if (mem_req && wait_cnt == 1) begin
                mem_ack  = 1'b1;
                wait_cnt = 0;
                if (mem_we) begin
                    chk(fill_n == 0, "R6 write-back before fill", fill_n, 0);
                    chk(mem_addr == wb_base + 32'(4 * wb_n), "R1 R6 write-back address",
                        mem_addr, wb_base + 32'(4 * wb_n));
                    chk(mem_wdata == ref_rd(mem_addr), "R6 write-back data",
                        mem_wdata, ref_rd(mem_addr));
                    bmem[mem_addr] = mem_wdata;
                    wb_n++;
                end else begin
                    chk(mem_addr == fill_base + 32'(4 * fill_n), "R1 R5 fill address",
                        mem_addr, fill_base + 32'(4 * fill_n));
                    mem_rdata = bm_rd(mem_addr);
                    fill_n++;
                end
                prev_wait = 0;
            end else begin
                mem_ack = 1'b0;
                if (mem_req) wait_cnt++;
                prev_wait = mem_req;
                prev_addr = mem_addr;
                prev_we   = mem_we;
            end
        end
    end

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        exp_wb;
        logic        exp_fill;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b10, 32'h0000_0000, 32'h0,          1'b0, 1'b1}, // R2 R5 first miss
        '{1'b0, 2'b10, 32'h0000_0004, 32'h0,          1'b0, 1'b0}, // R3 read hit
        '{1'b1, 2'b00, 32'h0000_0005, 32'h0000_00AB,  1'b0, 1'b0}, // R4 byte lane 1
        '{1'b0, 2'b10, 32'h0000_0004, 32'h0,          1'b0, 1'b0}, // R4 readback
        '{1'b1, 2'b01, 32'h0000_000A, 32'h0000_1234,  1'b0, 1'b0}, // R4 upper half
        '{1'b1, 2'b01, 32'h0000_0009, 32'h0000_BEEF,  1'b0, 1'b0}, // R4 addr[0] ignored
        '{1'b1, 2'b10, 32'h0000_0010, 32'hCAFE_F00D,  1'b0, 1'b1}, // R8 write miss
        '{1'b0, 2'b10, 32'h0000_0040, 32'h0,          1'b1, 1'b1}, // R6 dirty victim
        '{1'b0, 2'b10, 32'h0000_0000, 32'h0,          1'b0, 1'b1}, // R7 clean victim
        '{1'b0, 2'b10, 32'h0000_0008, 32'h0,          1'b0, 1'b0}, // R4 merged halves
        '{1'b0, 2'b10, 32'h0000_0050, 32'h0,          1'b1, 1'b1}, // R8 write-miss line evicted
        '{1'b1, 2'b11, 32'h0000_00FC, 32'h1122_3344,  1'b0, 1'b1}, // R8 last word, size 11
        '{1'b0, 2'b10, 32'h0000_00FC, 32'h0,          1'b0, 1'b0}, // R3 hit
        '{1'b1, 2'b00, 32'h0000_0103, 32'h0000_0077,  1'b0, 1'b1}, // R7 clean evict, byte 3
        '{1'b0, 2'b10, 32'h0000_0100, 32'h0,          1'b0, 1'b0}, // R4 byte 3 readback
        '{1'b0, 2'b10, 32'h0000_01F0, 32'h0,          1'b1, 1'b1}  // R6 evict last line
    };

    task automatic access(input vec_t v, input int n);
        logic [1:0]  idx = v.addr[5:4];
        logic [25:0] tg  = v.addr[31:6];
        logic [31:0] wa  = {v.addr[31:2], 2'b00};
        logic [31:0] rd;
        bit          hit = sh_v[idx] && sh_tag[idx] == tg;
        int          waits = 0;
        wb_base   = {sh_tag[idx], idx, 4'b0000};
        fill_base = {tg, idx, 4'b0000};
        wb_n      = 0;
        fill_n    = 0;
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = v.we;
        cpu_size  = v.sz;
        cpu_addr  = v.addr;
        cpu_wdata = v.wdata;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            waits++;
            if (waits > 500) begin
                chk(0, $sformatf("R9 vector %0d never ready", n), 32'(waits), 32'd0);
                break;
            end
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        chk((waits > 0) == !hit, $sformatf("R3 R9 vector %0d stall cycles", n),
            32'(waits), 32'(!hit));
        chk(wb_n == (v.exp_wb ? BW : 0), $sformatf("R6 R7 R8 vector %0d write-back words", n),
            32'(wb_n), v.exp_wb ? 32'(BW) : 32'd0);
        chk(fill_n == (v.exp_fill ? BW : 0), $sformatf("R5 vector %0d fill words", n),
            32'(fill_n), v.exp_fill ? 32'(BW) : 32'd0);
        if (v.we) begin
            refm[wa] = merge(ref_rd(wa), v.sz, v.addr, v.wdata);
        end else begin
            chk(rd == ref_rd(wa), $sformatf("R3 R4 vector %0d read data", n), rd, ref_rd(wa));
        end
        sh_d[idx]   = hit ? (sh_d[idx] | v.we) : v.we;
        sh_v[idx]   = 1'b1;
        sh_tag[idx] = tg;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen0;
        vec_t after;
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'b10;
        cpu_addr = '0; cpu_wdata = '0;
        for (int i = 0; i < NB; i++) begin sh_v[i] = 0; sh_d[i] = 0; sh_tag[i] = '0; end
        repeat (3) @(negedge clk);
        #1;
        chk(!cpu_ready, "R2 ready low in reset", 32'(cpu_ready), 32'd0);
        chk(!mem_req, "R2 no memory request in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        seen0 = mem_seen;
        repeat (8) @(negedge clk);
        chk(mem_seen == seen0, "R11 quiet after reset", 32'(mem_seen - seen0), 32'd0);

        for (int i = 0; i < NV; i++) access(VECS[i], i);

        seen0 = mem_seen;
        repeat (6) @(negedge clk);
        chk(mem_seen == seen0, "R11 quiet between requests", 32'(mem_seen - seen0), 32'd0);

        // R2: index 0 now holds a dirty line (vector 13); reset must drop it
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        refm.delete();
        for (int i = 0; i < NB; i++) begin sh_v[i] = 0; sh_d[i] = 0; end
        after = '{1'b0, 2'b10, 32'h0000_0100, 32'h0, 1'b0, 1'b1};
        access(after, 100);
        chk(bm_rd(32'h100) == init_val(32'h100), "R2 dirty line dropped by reset",
            bm_rd(32'h100), init_val(32'h100));

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule